// File: doc/BRIEF.md
# E1 Far-End Block Error Monitor

This block counts remote block error indications on an E1 receive path. In the CRC-4 multiframe, the far end reports each errored sub-multiframe by sending one of two designated bits as zero. The monitor picks those bits out of the received stream using frame-position strobes supplied by the framer. It counts every zero it sees, but only while the framer reports both basic frame alignment and CRC-4 multiframe alignment. Loss of CAS multiframe alignment does not stop it.

A host reads the 16-bit count over a byte-wide register bus. The upper byte is at one address and the lower byte is at the next address. Reading the upper byte takes a copy of the whole count and clears the live counter. The following lower-byte read returns the low half of that copy, so a read can never mix bytes from two different counts. An event in the same cycle as the clearing read is kept, and the counter then restarts at one. The count stops at its maximum instead of wrapping.

All interfaces are plain signals. The bit strobe and the read strobe are single-cycle qualifiers with no handshake and no back-pressure. The block samples one E-bit candidate per strobe and answers every read strobe on the next cycle.

Top module: `e1_febe_mon`

## Requirements
- R1: After reset the count and the lower-byte copy are zero, so reads at addresses 0x7 and 0x8 both return 0x00.
- R2: When `ebit_stb` is high, `frame_num` is 13 or 15 and `rx_bit` is 0, the count rises by one. A candidate with `rx_bit` equal to 1 leaves the count unchanged.
- R3: A strobe with `frame_num` other than 13 or 15 leaves the count unchanged, whatever the value of `rx_bit`.
- R4: While `fas_lock` is low, no event is counted.
- R5: While `crc_mf_lock` is low, no event is counted.
- R6: `cas_mf_lock` has no effect on counting.
- R7: A read at address 0x7 returns bits 15:8 of the count and stores bits 7:0 as a copy. A read at address 0x8 returns that stored copy.
- R8: A read at address 0x7 clears the live count. The next read pair returns only the events counted after that read.
- R9: An event in the same cycle as a read at address 0x7 is not lost, and the count restarts at 1.
- R10: The count saturates at 0xFFFF and does not wrap.
- R11: Read data appears on `host_rdata` in the cycle after `host_rd`. Any other address, and any cycle with no read, gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_num | input | 4 | Frame index within the CRC-4 multiframe |
| ebit_stb | input | 1 | Marks bit 1 of timeslot 0 on `rx_bit` |
| rx_bit | input | 1 | Received bit value |
| fas_lock | input | 1 | Basic frame alignment held |
| crc_mf_lock | input | 1 | CRC-4 multiframe alignment held |
| cas_mf_lock | input | 1 | CAS multiframe alignment held (does not gate counting) |
| host_rd | input | 1 | One-cycle read strobe |
| host_addr | input | 4 | Register address |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |

## Verification
Saturation is the hardest case to reach: random stimulus never gets close to 65535 unread events. A directed phase therefore drives one qualifying E-bit on every cycle with no reads for more than 65535 cycles, and then reads the pair. The bench also places events in the same cycle as upper-byte reads, both in directed steps and through random overlap. This covers the case where a clear and an increment meet.

// File: rtl/febe_pkg.sv
package febe_pkg;
  localparam int unsigned FRM_W      = 4;
  localparam int unsigned EBIT_FRM_A = 13;
  localparam int unsigned EBIT_FRM_B = 15;
  localparam int unsigned REG_HI     = 7;
  localparam int unsigned REG_LO     = 8;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_HI   = 2'd1,
    RSEL_LO   = 2'd2,
    RSEL_OTH  = 2'd3
  } rsel_e;
endpackage

// File: rtl/febe_ebit_pick.sv
module febe_ebit_pick
  import febe_pkg::*;
#(
  parameter int unsigned FW = FRM_W
) (
  input  logic          stb,
  input  logic [FW-1:0] frm,
  input  logic          bit_val,
  input  logic          fas_ok,
  input  logic          crc_ok,
  output logic          hit
);
  logic ebit_slot;
  always_comb begin
    ebit_slot = stb && ((frm == FW'(EBIT_FRM_A)) || (frm == FW'(EBIT_FRM_B)));
    hit       = ebit_slot && !bit_val && fas_ok && crc_ok;
  end
endmodule

// File: rtl/febe_sat_count.sv
module febe_sat_count #(
  parameter int unsigned W        = 16,
  parameter bit          SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic may_step;

  generate
    if (SATURATE) begin : g_sat
      assign may_step = (cnt != TOP);
    end else begin : g_wrap
      assign may_step = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= inc ? ONE : '0;
    else if (inc && may_step)  cnt <= cnt + ONE;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> cnt == '0); // R8
  AST_CLR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc |=> cnt == ONE); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !inc |=> $stable(cnt)); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    SATURATE && !clr && cnt == TOP |=> cnt == TOP); // R10
endmodule

// File: rtl/febe_rd_path.sv
module febe_rd_path
  import febe_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned HI_ADR = REG_HI,
  parameter int unsigned LO_ADR = REG_LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [2*DW-1:0] cnt,
  output logic          clr,
  output logic [DW-1:0] rdata
);
  rsel_e         sel;
  logic [DW-1:0] lo_copy;

  always_comb begin
    if (!rd)                        sel = RSEL_NONE;
    else if (addr == AW'(HI_ADR))   sel = RSEL_HI;
    else if (addr == AW'(LO_ADR))   sel = RSEL_LO;
    else                            sel = RSEL_OTH;
    clr = (sel == RSEL_HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      lo_copy <= '0;
    end else begin
      unique case (sel)
        RSEL_HI: begin
          rdata   <= cnt[2*DW-1:DW];
          lo_copy <= cnt[DW-1:0];
        end
        RSEL_LO: rdata <= lo_copy;
        default: rdata <= '0;
      endcase
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0); // R11
  AST_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rdata == $past(cnt[2*DW-1:DW])); // R7
  AST_LO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(lo_copy)); // R7
endmodule

// File: rtl/e1_febe_mon.sv
module e1_febe_mon
  import febe_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned HI_ADR   = REG_HI,
  parameter int unsigned LO_ADR   = REG_LO,
  parameter bit          SATURATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRM_W-1:0]  frame_num,
  input  logic              ebit_stb,
  input  logic              rx_bit,
  input  logic              fas_lock,
  input  logic              crc_mf_lock,
  input  logic              cas_mf_lock,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic             ev_hit;
  logic             rd_clr;
  logic [CNT_W-1:0] count;
  logic             cas_unused;

  assign cas_unused = cas_mf_lock;

  febe_ebit_pick #(.FW(FRM_W)) u_pick (
    .stb(ebit_stb), .frm(frame_num), .bit_val(rx_bit),
    .fas_ok(fas_lock), .crc_ok(crc_mf_lock), .hit(ev_hit)
  );

  febe_sat_count #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_hit), .clr(rd_clr), .cnt(count)
  );

  febe_rd_path #(.AW(ADDR_W), .DW(DATA_W), .HI_ADR(HI_ADR), .LO_ADR(LO_ADR)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .addr(host_addr),
    .cnt(count), .clr(rd_clr), .rdata(host_rdata)
  );

  AST_FAS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !fas_lock && !rd_clr |=> $stable(count)); // R4
  AST_CRC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_mf_lock && !rd_clr |=> $stable(count)); // R5
  AST_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_num != FRM_W'(EBIT_FRM_A) && frame_num != FRM_W'(EBIT_FRM_B) && !rd_clr
    |=> $stable(count)); // R3
endmodule

// File: tb/e1_febe_mon_tb_top.sv
module e1_febe_mon_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] frame_num = '0;
  logic       ebit_stb = 1'b0, rx_bit = 1'b1;
  logic       fas_lock = 1'b1, crc_mf_lock = 1'b1, cas_mf_lock = 1'b1;
  logic       host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int unsigned m_cnt = 0, m_lo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_febe_mon dut_i (
    .clk(clk), .rst_n(rst_n), .frame_num(frame_num), .ebit_stb(ebit_stb),
    .rx_bit(rx_bit), .fas_lock(fas_lock), .crc_mf_lock(crc_mf_lock),
    .cas_mf_lock(cas_mf_lock), .host_rd(host_rd), .host_addr(host_addr),
    .host_rdata(host_rdata)
  );

  function automatic bit is_event(logic [3:0] f, logic s, logic b, logic fa, logic cr);
    return s && (f == 4'd13 || f == 4'd15) && !b && fa && cr;
  endfunction

  function automatic string tag_for(logic rd, logic [3:0] a);
    if (!rd) return "R11";
    if (a == 4'd7) return "R7/R8";
    if (a == 4'd8) return "R7";
    return "R11";
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One cycle: drive after negedge, model at posedge, compare at next negedge.
  task automatic cyc(logic [3:0] f, logic s, logic b, logic fa, logic cr, logic ca,
                     logic rd, logic [3:0] a, string req = "");
    int exp_rd;
    bit ev;
    frame_num = f; ebit_stb = s; rx_bit = b;
    fas_lock = fa; crc_mf_lock = cr; cas_mf_lock = ca;
    host_rd = rd; host_addr = a;
    @(posedge clk);
    ev = is_event(f, s, b, fa, cr);
    exp_rd = 0;
    if (rd && a == 4'd7) begin
      exp_rd = (m_cnt >> 8) & 8'hFF;
      m_lo   = m_cnt & 8'hFF;
      m_cnt  = ev ? 1 : 0;
    end else begin
      if (rd && a == 4'd8) exp_rd = m_lo;
      if (ev && m_cnt < 16'hFFFF) m_cnt++;
    end
    @(negedge clk);
    check((req == "") ? tag_for(rd, a) : req, host_rdata, exp_rd);
  endtask

  task automatic rd_pair(string req);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd7, req);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd8, req);
  endtask

  task automatic expect_pair(string req, int val);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd7, req);
    check(req, host_rdata, (val >> 8) & 8'hFF);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd8, req);
    check(req, host_rdata, val & 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", host_rdata, 0);
    expect_pair("R1", 0);

    // R2: zeros in frames 13 and 15 count; ones do not
    cyc(13, 1, 0, 1, 1, 1, 0, 0);
    cyc(15, 1, 0, 1, 1, 1, 0, 0);
    cyc(13, 1, 1, 1, 1, 1, 0, 0);
    cyc(15, 1, 1, 1, 1, 1, 0, 0);
    cyc(13, 0, 0, 1, 1, 1, 0, 0);
    expect_pair("R2", 2);

    // R3: other frames ignored
    for (int f = 0; f < 16; f++) if (f != 13 && f != 15) cyc(f[3:0], 1, 0, 1, 1, 1, 0, 0);
    expect_pair("R3", 0);

    // R4 / R5 / R6 gating
    cyc(13, 1, 0, 0, 1, 1, 0, 0);
    cyc(15, 1, 0, 0, 0, 1, 0, 0);
    expect_pair("R4", 0);
    cyc(13, 1, 0, 1, 0, 1, 0, 0);
    cyc(15, 1, 0, 1, 0, 0, 0, 0);
    expect_pair("R5", 0);
    cyc(13, 1, 0, 1, 1, 0, 0, 0);
    cyc(15, 1, 0, 1, 1, 0, 0, 0);
    cyc(13, 1, 0, 1, 1, 0, 0, 0);
    expect_pair("R6", 3);

    // R7 / R8: the low byte comes from the snapshot even if events follow
    for (int i = 0; i < 300; i++) cyc(13, 1, 0, 1, 1, 1, 0, 0);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd7, "R7");
    check("R7", host_rdata, 8'h01);
    cyc(15, 1, 0, 1, 1, 1, 0, 0);
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd8, "R7");
    check("R7", host_rdata, 8'h2C);
    expect_pair("R8", 1);
    expect_pair("R8", 0);

    // R9: event in the same cycle as the clearing read
    cyc(13, 1, 0, 1, 1, 1, 0, 0);
    cyc(13, 1, 0, 1, 1, 1, 1, 4'd7, "R9");
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd8, "R9");
    check("R9", host_rdata, 1);
    expect_pair("R9", 1);

    // R11: unused addresses read zero
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd3, "R11");
    cyc(0, 0, 1, 1, 1, 1, 1, 4'd15, "R11");

    // R10: saturation
    for (int i = 0; i < 65540; i++) cyc(15, 1, 0, 1, 1, 1, 0, 0, "R10");
    expect_pair("R10", 16'hFFFF);
    expect_pair("R10", 0);

    // constrained random
    for (int i = 0; i < 30000; i++) begin
      logic [3:0] f, a;
      logic s, b, fa, cr, ca, rd;
      int unsigned r;
      f  = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd13 : 4'd15);
      s  = ($urandom % 2) == 0;
      b  = ($urandom % 3) == 0;
      fa = ($urandom % 10) != 0;
      cr = ($urandom % 10) != 0;
      ca = ($urandom % 2) == 0;
      r  = $urandom % 32;
      rd = (r < 3);
      a  = (r == 0) ? 4'd7 : (r == 1) ? 4'd8 : 4'($urandom);
      cyc(f, s, b, fa, cr, ca, rd, a);
    end
    rd_pair("R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule